// File: doc/BRIEF.md
# SPI Host Serial Port with Register Access

This block is a memory-mapped serial port that works as the host of an 8-bit SPI bus. Software sets the clock polarity, the clock phase, internal loopback and a wait-for-read option through a mode word. It sets the bit rate through a divider word and opens the receive and transmit paths with one-shot command bits. Each byte written to the transmit holding register is shifted out MSB first on MOSI. The same number of clocks captures one byte from MISO into the receive holding register, so every transfer is full duplex.

Three status flags are kept: receive-ready, transmit-ready and overrun. Separate set and clear registers maintain an interrupt mask over these flags, and a single interrupt line is raised when any unmasked flag is set. Chip selects are driven elsewhere.

Top module: `spih_port`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0x00000002, the mode (0x04) and divider (0x20) words read 0, the word at 0xFC reads the VERSION parameter (default 0x00000510), irq is low and sck is low.
- R2: The mode word keeps all 32 written bits. The divider word keeps its low 17 bits. Writes to offsets 0x14, 0x18 and 0xFC change nothing.
- R3: While a byte moves, the sck period is max(divider, 6) clock cycles and there are 8 leading edges per byte. Between bytes, sck rests at the polarity bit (mode bit 16).
- R4: Bytes go out and come in MSB first. With mode bit 8 clear, MISO is sampled on leading edges and MOSI changes on trailing edges. With it set, MOSI changes on leading edges and MISO is sampled on trailing ones. The received byte appears in bits 7:0 of offset 0x18.
- R5: With loopback (mode bit 15) set, the received byte equals the transmitted byte and the MISO pin has no effect.
- R6: Receive-ready (status bit 0) is set when a byte completes and is cleared by a read of offset 0x18. Transmit-ready (status bit 1) clears on a write to offset 0x1C and sets again when the byte enters the shifter.
- R7: Overrun (status bit 5) is set when a byte completes while receive-ready is still set. The newer byte replaces the held one. Overrun stays set until a receiver reset (control bit 2 at offset 0x00), which also clears receive-ready.
- R8: With wait-for-read (mode bit 20) set, a pending transmit byte does not start while receive-ready is set, so no overrun occurs.
- R9: The irq output is high exactly when some status bit among 0, 1 and 5 is set with its mask bit set. Writing 1s to offset 0x08 sets mask bits and writing 1s to offset 0x0C clears them. The status word shows the flags whatever the mask.
- R10: Control bits 4 and 6 enable the receiver and the transmitter, and bits 5 and 7 disable them (a disable wins). With the transmitter disabled, no byte starts. With the receiver disabled, a completed byte leaves receive-ready clear.
- R11: A transmitter reset (control bit 3) drops a pending transmit byte and sets transmit-ready, so that byte is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers every polarity, phase and loopback combination at dividers below, at and above the floor of 6, with a slave model that captures MOSI and drives MISO. A design that sampled on the wrong edge would return a byte shifted by one bit, and a bad divider clamp would show up as a short sck period. The flag corner cases include back-to-back bytes without a read, where overrun must appear and survive everything except a receiver reset. With wait-for-read set, a wrong design would start the second byte early. A pending byte is cleared by a transmitter reset, and a wrong design would still send it later. The bench also masks a flag that is set and checks that irq falls while the status word still shows the flag.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int DIV_W   = 17;
  localparam int MIN_DIV = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MSET = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MCLR = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_VER  = 8'hFC;

  // control command bits
  localparam int C_RX_RST = 2;
  localparam int C_TX_RST = 3;
  localparam int C_RX_ON  = 4;
  localparam int C_RX_OFF = 5;
  localparam int C_TX_ON  = 6;
  localparam int C_TX_OFF = 7;

  // mode bits used by the datapath
  localparam int M_CPHA = 8;
  localparam int M_LOOP = 15;
  localparam int M_CPOL = 16;
  localparam int M_WAIT = 20;

  // status / mask bit positions
  localparam int S_RXRDY = 0;
  localparam int S_TXRDY = 1;
  localparam int S_OVR   = 5;

  typedef struct packed {
    logic wait_rd;
    logic cpol;
    logic loop;
    logic cpha;
  } mode_t;

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : d;
  endfunction

  function automatic logic [DIV_W-1:0] first_half(input logic [DIV_W-1:0] d);
    return d >> 1;
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic ovr, input logic txr,
                                                    input logic rxr);
    logic [DATA_W-1:0] w;
    w = '0;
    w[S_OVR]   = ovr;
    w[S_TXRDY] = txr;
    w[S_RXRDY] = rxr;
    return w;
  endfunction
endpackage

// File: rtl/spih_regs.sv
module spih_regs
  import spih_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0510
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              start,
  output logic [7:0]        thr_q,
  output mode_t             mode,
  output logic [DIV_W-1:0]  div_eff,
  output logic              irq,
  output logic              rx_rdy,
  output logic              tx_rdy,
  output logic              ovr,
  output logic              rx_rst,
  output logic              tx_rst,
  output logic              rhr_rd,
  output logic              thr_wr,
  output logic              rx_en,
  output logic              tx_en
);
  logic [DATA_W-1:0] mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [2:0]        mask_q;   // {ovr, txrdy, rxrdy}
  logic [7:0]        rhr_q;
  logic              thr_full;
  logic              wr_ctrl, wr_mode, wr_mset, wr_mclr, wr_div;
  logic              rx_store;
  logic [2:0]        flags;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign wr_mode = bus_sel && bus_wr && (bus_addr == OFS_MODE);
  assign wr_mset = bus_sel && bus_wr && (bus_addr == OFS_MSET);
  assign wr_mclr = bus_sel && bus_wr && (bus_addr == OFS_MCLR);
  assign wr_div  = bus_sel && bus_wr && (bus_addr == OFS_DIV);
  assign thr_wr  = bus_sel && bus_wr && (bus_addr == OFS_TXD);
  assign rhr_rd  = bus_sel && !bus_wr && (bus_addr == OFS_RXD);
  assign rx_rst  = wr_ctrl && bus_wdata[C_RX_RST];
  assign tx_rst  = wr_ctrl && bus_wdata[C_TX_RST];

  assign mode.wait_rd = mode_q[M_WAIT];
  assign mode.cpol    = mode_q[M_CPOL];
  assign mode.loop    = mode_q[M_LOOP];
  assign mode.cpha    = mode_q[M_CPHA];
  assign div_eff      = eff_div(div_q);
  assign tx_rdy       = !thr_full;
  assign rx_store     = byte_done && rx_en;

  assign start = thr_full && tx_en && !busy && !tx_rst && !(mode.wait_rd && rx_rdy);

  assign flags = {ovr, tx_rdy, rx_rdy};
  assign irq   = |(flags & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      mask_q <= '0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_mset || wr_mclr)
        mask_q <= (mask_q | ({3{wr_mset}} & {bus_wdata[S_OVR], bus_wdata[S_TXRDY], bus_wdata[S_RXRDY]}))
                & ~({3{wr_mclr}} & {bus_wdata[S_OVR], bus_wdata[S_TXRDY], bus_wdata[S_RXRDY]});
      if (wr_ctrl) begin
        if (bus_wdata[C_RX_OFF])     rx_en <= 1'b0;
        else if (bus_wdata[C_RX_ON]) rx_en <= 1'b1;
        if (bus_wdata[C_TX_OFF])     tx_en <= 1'b0;
        else if (bus_wdata[C_TX_ON]) tx_en <= 1'b1;
      end
    end
  end

  // receive side: reset beats completion beats read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0;
      ovr    <= 1'b0;
      rhr_q  <= '0;
    end else if (rx_rst) begin
      rx_rdy <= 1'b0;
      ovr    <= 1'b0;
      rhr_q  <= '0;
    end else if (rx_store) begin
      rhr_q  <= rx_byte;
      rx_rdy <= 1'b1;
      if (rx_rdy && !rhr_rd) ovr <= 1'b1;
    end else if (rhr_rd) begin
      rx_rdy <= 1'b0;
    end
  end

  // transmit holding: a write in the start cycle refills it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_full <= 1'b0;
      thr_q    <= '0;
    end else if (tx_rst) begin
      thr_full <= 1'b0;
    end else if (thr_wr) begin
      thr_full <= 1'b1;
      thr_q    <= bus_wdata[7:0];
    end else if (start) begin
      thr_full <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_q;
      OFS_STAT: bus_rdata = status_word(ovr, tx_rdy, rx_rdy);
      OFS_RXD:  bus_rdata = {{(DATA_W-8){1'b0}}, rhr_q};
      OFS_DIV:  bus_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
      OFS_VER:  bus_rdata = VERSION;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spih_baud.sv
module spih_baud
  import spih_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             edge_p,
  output logic             lead
);
  logic [DIV_W-1:0] cnt;
  logic             phase;   // 0: counting toward a leading edge
  logic [DIV_W-1:0] lo_len, hi_len, cur_len;

  assign lo_len  = first_half(div);
  assign hi_len  = div - lo_len;
  assign cur_len = phase ? hi_len : lo_len;
  assign edge_p  = run && (cnt == cur_len - 1'b1);
  assign lead    = !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (edge_p) begin
      cnt   <= '0;
      phase <= !phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spih_shift.sv
module spih_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [BITS-1:0] load_byte,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            loop,
  input  logic            miso,
  input  logic            edge_p,
  input  logic            lead,
  output logic            busy,
  output logic            sck,
  output logic            mosi,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  localparam int EDGES = 2 * BITS;
  localparam int EC_W  = $clog2(EDGES);

  logic [EC_W-1:0] ecnt;
  logic [BITS-1:0] tx_sh, rx_sh;
  logic            sck_q, mosi_q, miso_in;
  logic            samp_e, shift_e, last_e;

  assign sck     = sck_q ^ cpol;
  assign mosi    = cpha ? mosi_q : tx_sh[BITS-1];
  assign miso_in = loop ? mosi : miso;
  assign samp_e  = busy && edge_p && (lead ^ cpha);
  assign shift_e = busy && edge_p && !(lead ^ cpha);
  assign last_e  = busy && edge_p && (ecnt == EC_W'(EDGES - 1));
  assign byte_done = last_e && !abort;
  assign rx_byte = cpha ? {rx_sh[BITS-2:0], miso_in} : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sck_q  <= 1'b0;
      ecnt   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      mosi_q <= 1'b0;
    end else if (abort) begin
      busy  <= 1'b0;
      sck_q <= 1'b0;
      ecnt  <= '0;
      tx_sh <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sck_q  <= 1'b0;
      ecnt   <= '0;
      tx_sh  <= load_byte;
      rx_sh  <= '0;
      mosi_q <= load_byte[BITS-1];
    end else if (busy && edge_p) begin
      sck_q <= !sck_q;
      ecnt  <= ecnt + 1'b1;
      if (samp_e) rx_sh <= {rx_sh[BITS-2:0], miso_in};
      if (shift_e) begin
        mosi_q <= tx_sh[BITS-1];
        tx_sh  <= {tx_sh[BITS-2:0], 1'b0};
      end
      if (last_e) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spih_port.sv
module spih_port
  import spih_pkg::*;
#(
  parameter logic [31:0] VERSION = 32'h0000_0510
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  logic             busy, byte_done, start, edge_p, lead;
  logic [7:0]       rx_byte, thr_q;
  mode_t            mode;
  logic [DIV_W-1:0] div_eff;
  logic             rx_rdy, tx_rdy, ovr, rx_rst, tx_rst, rhr_rd, thr_wr, rx_en, tx_en;
  logic             cpol;

  assign cpol = mode.cpol;

  spih_regs #(.VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .byte_done(byte_done),
    .rx_byte(rx_byte), .start(start), .thr_q(thr_q), .mode(mode), .div_eff(div_eff),
    .irq(irq), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .ovr(ovr), .rx_rst(rx_rst),
    .tx_rst(tx_rst), .rhr_rd(rhr_rd), .thr_wr(thr_wr), .rx_en(rx_en), .tx_en(tx_en)
  );

  spih_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_eff), .edge_p(edge_p), .lead(lead)
  );

  spih_shift #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(tx_rst), .load_byte(thr_q),
    .cpol(mode.cpol), .cpha(mode.cpha), .loop(mode.loop), .miso(miso),
    .edge_p(edge_p), .lead(lead), .busy(busy), .sck(sck), .mosi(mosi),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spih_port_chk.sv
module spih_port_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck,
  input logic cpol,
  input logic irq,
  input logic rx_rdy,
  input logic tx_rdy,
  input logic ovr,
  input logic rx_rst,
  input logic tx_rst,
  input logic rhr_rd,
  input logic thr_wr,
  input logic byte_done,
  input logic start,
  input logic tx_en,
  input logic rx_en,
  input logic wait_rd
);
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_rdy && !tx_rdy && !ovr) |-> !irq);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_rd && !byte_done) |=> !rx_rdy);

  p_thr_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_rst) |=> !tx_rdy);

  p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rx_rst) |=> ovr);

  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rx_en && rx_rdy && !rhr_rd && !rx_rst) |=> ovr);

  p_rx_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (!ovr && !rx_rdy));

  p_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_rd && rx_rdy) |-> !start);

  p_tx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !start);

  p_tx_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (tx_rdy && !busy));
endmodule

bind spih_port spih_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .cpol(cpol), .irq(irq),
  .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .ovr(ovr), .rx_rst(rx_rst), .tx_rst(tx_rst),
  .rhr_rd(rhr_rd), .thr_wr(thr_wr), .byte_done(byte_done), .start(start),
  .tx_en(tx_en), .rx_en(rx_en), .wait_rd(mode.wait_rd)
);

// File: tb/tb_spih_port.sv
module tb_spih_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;

  int nchk = 0, nerr = 0;
  int cyc = 0;

  spih_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // slave model
  bit       slv_on = 0, b_cpol = 0, b_cpha = 0;
  bit [7:0] slv_tx, slv_rx;
  int       bitn = 0, lead_cnt = 0, last_lead = 0, pmin = 0, pmax = 0, any_edges = 0;

  always @(sck) begin
    any_edges++;
    if (slv_on) begin
      if (sck != b_cpol) begin
        if (lead_cnt > 0) begin
          if (cyc - last_lead < pmin) pmin = cyc - last_lead;
          if (cyc - last_lead > pmax) pmax = cyc - last_lead;
        end
        last_lead = cyc;
        lead_cnt++;
        if (!b_cpha) slv_rx = {slv_rx[6:0], mosi};
        else if (bitn < 8) miso = slv_tx[7-bitn];
      end else begin
        if (!b_cpha) begin
          bitn++;
          if (bitn < 8) miso = slv_tx[7-bitn];
        end else begin
          slv_rx = {slv_rx[6:0], mosi};
          bitn++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_rx();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h14, s);
      if (s[0]) return;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_mode(input bit pol, input bit pha, input bit lp, input bit wt);
    return 32'h0004_00CE | (32'(pha) << 8) | (32'(lp) << 15) | (32'(pol) << 16) | (32'(wt) << 20);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int idx;
    int divs[5] = '{0, 5, 6, 7, 10};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h14, v); chk("R1 status", v, 32'h2);
    rd(8'h04, v); chk("R1 mode", v, 0);
    rd(8'h20, v); chk("R1 divider", v, 0);
    rd(8'hFC, v); chk("R1 version", v, 32'h0000_0510);
    chk("R1 irq", irq, 0);
    chk("R1 sck", sck, 0);

    // R2 register storage and read-only words
    wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, v); chk("R2 mode", v, 32'hDEAD_BEEF);
    wr(8'h04, 0);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R2 divider", v, 32'h0001_FFFF);
    wr(8'hFC, 0); rd(8'hFC, v); chk("R2 version ro", v, 32'h0000_0510);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R2 status ro", v, 32'h2);
    wr(8'h18, 32'hFF); rd(8'h18, v); chk("R2 rxd ro", v, 0);

    // R3 R4 R5 sweep
    wr(8'h00, 32'h50);
    idx = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int lp = 0; lp < 2; lp++)
          for (int di = 0; di < 5; di++) begin
            logic [7:0] tb_tx, tb_sl;
            int ediv;
            tb_tx = 8'hA5 ^ 8'(idx * 37);
            tb_sl = 8'h3C ^ 8'(idx * 53);
            ediv = (divs[di] < 6) ? 6 : divs[di];
            wr(8'h04, mk_mode(pol[0], pha[0], lp[0], 0));
            wr(8'h20, 32'(divs[di]));
            b_cpol = pol[0]; b_cpha = pha[0];
            slv_tx = tb_sl; slv_rx = 0; bitn = 0; lead_cnt = 0;
            pmin = 1000000; pmax = 0;
            miso = pha[0] ? 1'b0 : tb_sl[7];
            slv_on = 1;
            wr(8'h1C, 32'(tb_tx));
            wait_rx();
            slv_on = 0;
            chk("R3 idle level", sck, pol);
            chk("R3 leading edges", lead_cnt, 8);
            chk("R3 period min", pmin, ediv);
            chk("R3 period max", pmax, ediv);
            chk("R4 slave got", slv_rx, tb_tx);
            rd(8'h18, v);
            if (lp) chk("R5 loopback rx", v, 32'(tb_tx));
            else    chk("R4 host rx", v, 32'(tb_sl));
            idx++;
          end

    wr(8'h04, mk_mode(0, 0, 1, 0));
    wr(8'h20, 6);

    // R6 flags
    rd(8'h14, v); chk("R6 idle status", v, 32'h2);
    wr(8'h00, 32'h80);
    wr(8'h1C, 32'h5A);
    rd(8'h14, v); chk("R6 txrdy after write", v, 32'h0);
    wr(8'h00, 32'h40);
    idle(3);
    rd(8'h14, v); chk("R6 txrdy after load", v[1], 1);
    wait_rx();
    rd(8'h14, v); chk("R6 rxrdy set", v, 32'h3);
    rd(8'h18, v); chk("R6 rx data", v, 32'h5A);
    rd(8'h14, v); chk("R6 rxrdy cleared", v, 32'h2);

    // R9 mask and irq
    wr(8'h08, 32'h2); chk("R9 irq txrdy", irq, 1);
    wr(8'h0C, 32'h2); chk("R9 irq masked", irq, 0);
    wr(8'h08, 32'h1); chk("R9 irq rx idle", irq, 0);
    wr(8'h1C, 32'h77); wait_rx();
    chk("R9 irq rxrdy", irq, 1);
    wr(8'h0C, 32'h1); chk("R9 irq cleared mask", irq, 0);
    rd(8'h14, v); chk("R9 raw status", v, 32'h3);
    rd(8'h18, v);

    // R7 overrun
    wr(8'h08, 32'h20);
    wr(8'h1C, 32'h11); wait_rx();
    chk("R7 no irq yet", irq, 0);
    wr(8'h1C, 32'h22); idle(100);
    rd(8'h14, v); chk("R7 overrun set", v, 32'h23);
    chk("R7 irq", irq, 1);
    rd(8'h18, v); chk("R7 newest byte", v, 32'h22);
    rd(8'h14, v); chk("R7 overrun sticky", v, 32'h22);
    wr(8'h00, 32'h04);
    rd(8'h14, v); chk("R7 rx reset", v, 32'h2);
    chk("R7 irq after reset", irq, 0);
    wr(8'h0C, 32'h20);

    // R8 wait-for-read
    wr(8'h04, mk_mode(0, 0, 1, 1));
    wr(8'h1C, 32'h33); wait_rx();
    wr(8'h1C, 32'h44); idle(100);
    rd(8'h14, v); chk("R8 held", v, 32'h1);
    rd(8'h18, v); chk("R8 first byte", v, 32'h33);
    idle(100);
    rd(8'h14, v); chk("R8 released", v, 32'h3);
    rd(8'h18, v); chk("R8 second byte", v, 32'h44);
    wr(8'h04, mk_mode(0, 0, 1, 0));

    // R10 enables
    wr(8'h00, 32'hC0);
    any_edges = 0;
    wr(8'h1C, 32'h99); idle(100);
    chk("R10 tx off no sck", any_edges, 0);
    rd(8'h14, v); chk("R10 tx off pending", v, 32'h0);
    wr(8'h00, 32'h60);
    idle(100);
    chk("R10 byte sent", any_edges, 16);
    rd(8'h14, v); chk("R10 rx off no rxrdy", v, 32'h2);
    wr(8'h00, 32'h10);

    // R11 transmitter reset drops pending byte
    wr(8'h00, 32'h80);
    wr(8'h1C, 32'hC3);
    wr(8'h00, 32'h08);
    rd(8'h14, v); chk("R11 txrdy restored", v, 32'h2);
    any_edges = 0;
    wr(8'h00, 32'h40); idle(100);
    chk("R11 nothing sent", any_edges, 0);
    rd(8'h14, v); chk("R11 no rx", v, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule